// File: doc/BRIEF.md
# Triggered PWM Timer Core

This block is a 16-bit up-counting timer that drives one waveform pin. The count climbs from zero to a reload limit, wraps, and the pin is at its active level while the count is above a compare threshold. Counting begins on a software start request or on a selected edge of an external trigger that has already been filtered. One start mechanism serves three behaviours. One-shot runs a single period per accepted trigger. Continuous runs freely after the first trigger. Set-once starts only once and leaves the pin latched active. A timeout option lets each later trigger restart the count from zero, so a compare match that is reached marks a missed trigger.

The limit and threshold come from configuration ports. They either apply at once or wait in shadow registers until an update event. An update event is an overflow that an external repetition block lets through on `upd_gate`. Three sticky flags record compare matches, overflows and accepted triggers. Each is cleared by a one-cycle pulse. A count-enable input advances the counter only in cycles where it is high, which lets an outside prescaler set the rate.

Top module: `trig_pwm_timer`

## Requirements
- R1: After reset `running` is 0, `count` is 0, all three flags are 0 and `wave_out` equals `polarity`.
- R2: While running and `cnt_en` is high, the count advances by one per cycle from 0 to `arr_val` and then returns to 0 (an overflow). `wave_out` is active (equal to `!polarity`) exactly while the count is greater than `cmp_val`, so each period of `arr_val`+1 cycles holds `arr_val`-`cmp_val` active cycles.
- R3: With `trig_sel` = 00 (software), a start pulse sampled at a rising edge makes `running` go high after the third rising edge, counting that sampling edge, with the count at 0.
- R4: A start pulse sampled while `enable` is low is dropped. Driving `enable` low stops the counter, zeroes the count and clears all pending starts and modes.
- R5: A start through `start_single` selects one-shot. The counter stops with count 0 at the first update event, and a later accepted trigger starts a new period.
- R6: In one-shot mode, a trigger that arrives while the counter runs is discarded. The count is not reset.
- R7: A start through `start_cont` selects continuous mode. The counter keeps running across overflows and ignores later triggers.
- R8: With `set_once` high, only the first trigger after enable starts the counter. Once the count has exceeded `cmp_val`, `wave_out` stays active even after the counter stops. Later triggers have no effect.
- R9: With `timeout_en` high, an accepted trigger while running resets the count to 0 two cycles after it is sampled, and counting continues. Reaching `cmp_val` without a further trigger sets the compare flag.
- R10: With `trig_sel` = 01, 10 or 11, the counter starts on a rising, a falling or either edge of `ext_trig`. The counter starts after the third rising edge, counting the edge that first samples the new level. Edges of a kind that is not selected are ignored.
- R11: `flag_trig` is set only by a trigger that starts or restarts the count, `flag_cmp` by a count step at `cmp_val`, and `flag_arr` by an overflow. Each flag stays set until its clear pulse. A set in the same cycle as the clear wins.
- R12: A single request while running continuously makes the counter stop at the next update event. A continuous request during a one-shot makes the counter continue past `arr_val`.
- R13: `polarity` inverts `wave_out` combinationally, including while `enable` is low.
- R14: With `preload` high, new `arr_val`/`cmp_val` values take effect only at an update event, that is an overflow while `upd_gate` is high. With `preload` low they take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Timer enable; low clears counting state |
| trig_sel | input | 2 | 00 software, 01 rising, 10 falling, 11 both edges |
| start_single | input | 1 | One-cycle request for one-shot operation |
| start_cont | input | 1 | One-cycle request for continuous operation |
| ext_trig | input | 1 | Filtered external trigger level |
| cnt_en | input | 1 | Count step enable |
| timeout_en | input | 1 | Later triggers restart the count |
| set_once | input | 1 | Single start, latched active output |
| polarity | input | 1 | Output inversion |
| preload | input | 1 | Hold new limit and threshold until update event |
| upd_gate | input | 1 | Repetition block lets this overflow be an update event |
| arr_val | input | 16 | Reload limit |
| cmp_val | input | 16 | Compare threshold |
| clr_cmp | input | 1 | Clear pulse for compare flag |
| clr_arr | input | 1 | Clear pulse for overflow flag |
| clr_trig | input | 1 | Clear pulse for trigger flag |
| wave_out | output | 1 | Waveform output |
| count | output | 16 | Current count |
| running | output | 1 | Counter is active |
| upd_evt | output | 1 | Update event pulse |
| flag_cmp | output | 1 | Sticky compare-match flag |
| flag_arr | output | 1 | Sticky overflow flag |
| flag_trig | output | 1 | Sticky accepted-trigger flag |

## Verification
A wrong mode or arming bit shows up at the next trigger or overflow. The counter either stops when it should wrap, keeps running when it should stop, or the count fails to return to zero within two cycles of a timeout trigger. A fault in the synchronizer or the software start pipeline moves the rise of `running` away from its third-edge slot, and the bench samples that slot exactly. Shadow-register faults appear within one period as a wrap at the wrong count. Output-logic faults change the count of active cycles in the first full period.

// File: rtl/tpt_pkg.sv
// Shared definitions for the triggered PWM timer.
// Assumes: trigger source codes are fixed by the configuration port encoding.
package tpt_pkg;
    typedef enum logic [1:0] {
        TRG_SW   = 2'b00,
        TRG_RISE = 2'b01,
        TRG_FALL = 2'b10,
        TRG_BOTH = 2'b11
    } trg_sel_e;

    localparam int NFLAG    = 3;
    localparam int FLG_TRIG = 0;
    localparam int FLG_ARR  = 1;
    localparam int FLG_CMP  = 2;
endpackage

// File: rtl/tpt_trig_detect.sv
// Turns the external trigger level or a software start request into one
// trigger-event pulse. External edges pass a SYNC_STAGES synchronizer and an
// edge detector. Software requests pass a delay pipeline of equal length, so
// both paths start the counter on the same edge after sampling.
// Assumes: ext_trig is already glitch-filtered.
module tpt_trig_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] trig_sel,
    input  logic       ext_trig,
    input  logic       sw_req,
    output logic       trig_ev
);
    import tpt_pkg::*;

    localparam int SHW = SYNC_STAGES + 1;

    logic [SHW-1:0]         sync_q;
    logic [SYNC_STAGES-1:0] sw_q;
    logic                   cur_lvl;
    logic                   prev_lvl;
    logic                   ext_ev;
    trg_sel_e               sel;

    // Synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SHW-2:0], ext_trig};
    end

    // Software request delay pipeline, flushed while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) sw_q <= '0;
        else                   sw_q <= {sw_q[SYNC_STAGES-2:0], sw_req};
    end

    assign cur_lvl  = sync_q[SYNC_STAGES-1];
    assign prev_lvl = sync_q[SYNC_STAGES];
    assign sel      = trg_sel_e'(trig_sel);

    // Select the active edge kind and the software path.
    always_comb begin
        case (sel)
            TRG_RISE: ext_ev = cur_lvl & ~prev_lvl;
            TRG_FALL: ext_ev = ~cur_lvl & prev_lvl;
            TRG_BOTH: ext_ev = cur_lvl ^ prev_lvl;
            default:  ext_ev = 1'b0;
        endcase
        trig_ev = (sel == TRG_SW) ? sw_q[SYNC_STAGES-1] : ext_ev;
    end
endmodule

// File: rtl/tpt_start_ctrl.sv
// Arming, mode and run-state control. A start request arms the timer and
// picks one-shot or continuous mode. A trigger then starts an idle counter,
// or restarts a running one when timeout is on. Set-once allows one start.
// Assumes: upd_ev only pulses while running.
module tpt_start_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req_single,
    input  logic req_cont,
    input  logic trig_ev,
    input  logic timeout_en,
    input  logic set_once,
    input  logic upd_ev,
    output logic running,
    output logic cont_mode,
    output logic start_go,
    output logic retrig
);
    logic armed_q;
    logic fired_q;
    logic run_q;
    logic cont_q;
    logic blocked;
    logic accept_ok;

    assign blocked   = set_once & fired_q;
    assign accept_ok = enable & armed_q & trig_ev & ~blocked;
    assign start_go  = accept_ok & ~run_q;
    assign retrig    = accept_ok & run_q & timeout_en;
    assign running   = run_q;
    assign cont_mode = cont_q;

    // Track arming, mode, run state and the set-once lockout.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed_q <= 1'b0;
            fired_q <= 1'b0;
            run_q   <= 1'b0;
            cont_q  <= 1'b0;
        end else begin
            if (req_single) begin
                armed_q <= 1'b1;
                cont_q  <= 1'b0;
            end else if (req_cont) begin
                armed_q <= 1'b1;
                cont_q  <= 1'b1;
            end
            if (start_go)                run_q <= 1'b1;
            else if (upd_ev && !cont_q)  run_q <= 1'b0;
            if (start_go && set_once)    fired_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tpt_count_core.sv
// Up-counter with reload limit and compare threshold, including shadow
// registers for preloaded updates and the match events.
// Assumes: the limit is above the threshold while counting.
module tpt_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         running,
    input  logic         cnt_en,
    input  logic         restart,
    input  logic         preload,
    input  logic         upd_gate,
    input  logic [W-1:0] arr_in,
    input  logic [W-1:0] cmp_in,
    output logic [W-1:0] count,
    output logic [W-1:0] arr_eff,
    output logic         ovf_ev,
    output logic         upd_ev,
    output logic         cmp_ev,
    output logic         active
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] arr_sh;
    logic [W-1:0] cmp_sh;
    logic [W-1:0] cmp_eff;
    logic         step;

    assign arr_eff = preload ? arr_sh : arr_in;
    assign cmp_eff = preload ? cmp_sh : cmp_in;
    assign step    = running & cnt_en & ~restart;
    assign ovf_ev  = step & (cnt_q == arr_eff);
    assign upd_ev  = ovf_ev & upd_gate;
    assign cmp_ev  = step & (cnt_q == cmp_eff);
    assign active  = cnt_q > cmp_eff;
    assign count   = cnt_q;

    // Shadow registers follow the inputs while idle and load at update events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_sh <= '0;
            cmp_sh <= '0;
        end else if (!running || upd_ev) begin
            arr_sh <= arr_in;
            cmp_sh <= cmp_in;
        end
    end

    // Main counter: cleared on disable, restart or overflow, else steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (restart)      cnt_q <= '0;
        else if (ovf_ev)       cnt_q <= '0;
        else if (step)         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tpt_flag_bank.sv
// Bank of sticky status flags. Set has priority over a same-cycle clear.
// Assumes: set and clear are single-cycle pulses in the clk domain.
module tpt_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold flag g until its clear pulse; a set overrides the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flags[g] <= 1'b0;
            else if (set_i[g]) flags[g] <= 1'b1;
            else if (clr_i[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/trig_pwm_timer.sv
// Top of the triggered PWM timer: trigger detection, start control, counter
// core, sticky flags and waveform output with the set-once latch.
// Assumes: trigger and count-enable inputs are clean and synchronous.
module trig_pwm_timer #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [1:0]   trig_sel,
    input  logic         start_single,
    input  logic         start_cont,
    input  logic         ext_trig,
    input  logic         cnt_en,
    input  logic         timeout_en,
    input  logic         set_once,
    input  logic         polarity,
    input  logic         preload,
    input  logic         upd_gate,
    input  logic [W-1:0] arr_val,
    input  logic [W-1:0] cmp_val,
    input  logic         clr_cmp,
    input  logic         clr_arr,
    input  logic         clr_trig,
    output logic         wave_out,
    output logic [W-1:0] count,
    output logic         running,
    output logic         upd_evt,
    output logic         flag_cmp,
    output logic         flag_arr,
    output logic         flag_trig
);
    import tpt_pkg::*;

    logic             req_single;
    logic             req_cont;
    logic             trig_ev;
    logic             start_go;
    logic             retrig;
    logic             cont_mode;
    logic             ovf_ev;
    logic             cmp_ev;
    logic             active;
    logic             so_latch;
    logic [W-1:0]     arr_eff;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_q;

    assign req_single = enable & start_single;
    assign req_cont   = enable & start_cont;

    tpt_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .trig_sel (trig_sel),
        .ext_trig (ext_trig),
        .sw_req   (req_single | req_cont),
        .trig_ev  (trig_ev)
    );

    tpt_start_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .req_single (req_single),
        .req_cont   (req_cont),
        .trig_ev    (trig_ev),
        .timeout_en (timeout_en),
        .set_once   (set_once),
        .upd_ev     (upd_evt),
        .running    (running),
        .cont_mode  (cont_mode),
        .start_go   (start_go),
        .retrig     (retrig)
    );

    tpt_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .running  (running),
        .cnt_en   (cnt_en),
        .restart  (start_go | retrig),
        .preload  (preload),
        .upd_gate (upd_gate),
        .arr_in   (arr_val),
        .cmp_in   (cmp_val),
        .count    (count),
        .arr_eff  (arr_eff),
        .ovf_ev   (ovf_ev),
        .upd_ev   (upd_evt),
        .cmp_ev   (cmp_ev),
        .active   (active)
    );

    assign flag_set[FLG_TRIG] = start_go | retrig;
    assign flag_set[FLG_ARR]  = ovf_ev;
    assign flag_set[FLG_CMP]  = cmp_ev;
    assign flag_clr[FLG_TRIG] = clr_trig;
    assign flag_clr[FLG_ARR]  = clr_arr;
    assign flag_clr[FLG_CMP]  = clr_cmp;

    tpt_flag_bank #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .flags (flag_q)
    );

    assign flag_trig = flag_q[FLG_TRIG];
    assign flag_arr  = flag_q[FLG_ARR];
    assign flag_cmp  = flag_q[FLG_CMP];

    // Set-once latch: remembers that the output has gone active.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !set_once) so_latch <= 1'b0;
        else if (active)                    so_latch <= 1'b1;
    end

    assign wave_out = (active | (set_once & so_latch)) ^ polarity;
endmodule

// File: rtl/tpt_checker.sv
// Property checker for the triggered PWM timer, attached by bind.
// Assumes: sampled on the kernel clock with synchronous active-low reset.
module tpt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         polarity,
    input logic         running,
    input logic         cnt_en,
    input logic [W-1:0] count,
    input logic [W-1:0] arr_eff,
    input logic         start_go,
    input logic         retrig,
    input logic         flag_trig,
    input logic         clr_trig,
    input logic         wave_out
);
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && cnt_en && !retrig && count == arr_eff) |=> count == '0);

    p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!running && count == '0));

    p_retrig_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && retrig) |=> count == '0);

    p_trig_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_trig && !$past(flag_trig)) |-> $past(start_go || retrig));

    p_trig_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_trig && !clr_trig) |=> flag_trig);

    p_idle_polarity_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> wave_out == polarity);
endmodule

bind trig_pwm_timer tpt_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .polarity  (polarity),
    .running   (running),
    .cnt_en    (cnt_en),
    .count     (count),
    .arr_eff   (arr_eff),
    .start_go  (start_go),
    .retrig    (retrig),
    .flag_trig (flag_trig),
    .clr_trig  (clr_trig),
    .wave_out  (wave_out)
);

// File: tb/trig_pwm_timer_tb.sv
// Self-checking bench for trig_pwm_timer: a vector table of PWM settings
// walked in one loop, then directed tests for start, modes and corners.
module trig_pwm_timer_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [1:0]   trig_sel = 2'b00;
    logic         start_single = 1'b0;
    logic         start_cont = 1'b0;
    logic         ext_trig = 1'b0;
    logic         cnt_en = 1'b1;
    logic         timeout_en = 1'b0;
    logic         set_once = 1'b0;
    logic         polarity = 1'b0;
    logic         preload = 1'b0;
    logic         upd_gate = 1'b1;
    logic [W-1:0] arr_val = 16'd5;
    logic [W-1:0] cmp_val = 16'd2;
    logic         clr_cmp = 1'b0;
    logic         clr_arr = 1'b0;
    logic         clr_trig = 1'b0;
    logic         wave_out;
    logic [W-1:0] count;
    logic         running;
    logic         upd_evt;
    logic         flag_cmp;
    logic         flag_arr;
    logic         flag_trig;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Columns: reload limit, threshold, polarity, expected active cycles.
    localparam int NVEC = 5;
    localparam int TBL[NVEC][4] = '{
        '{5, 2, 0, 3},
        '{7, 0, 0, 7},
        '{3, 2, 1, 1},
        '{9, 4, 1, 5},
        '{1, 0, 0, 1}
    };

    trig_pwm_timer #(.W(W)) u_dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic renable();
        enable = 1'b0;
        tick(2);
        enable = 1'b1;
        tick(1);
    endtask

    task automatic pulse_single();
        start_single = 1'b1;
        tick(1);
        start_single = 1'b0;
    endtask

    task automatic pulse_cont();
        start_cont = 1'b1;
        tick(1);
        start_cont = 1'b0;
    endtask

    task automatic wait_stop(input int lim);
        for (int i = 0; i < lim && running; i++) tick(1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=finish", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(!running && count == 0, "R1 idle after reset", int'(count), 0);
        chk({flag_cmp, flag_arr, flag_trig} == 3'b000, "R1 flags clear",
            int'({flag_cmp, flag_arr, flag_trig}), 0);
        chk(wave_out == 1'b0, "R1 output at polarity", int'(wave_out), 0);

        // R13 polarity inverts at once while disabled
        polarity = 1'b1;
        #1;
        chk(wave_out == 1'b1, "R13 polarity while disabled", int'(wave_out), 1);
        polarity = 1'b0;
        #1;
        chk(wave_out == 1'b0, "R13 polarity back", int'(wave_out), 0);

        // R4 start dropped while disabled
        pulse_cont();
        enable = 1'b1;
        tick(5);
        chk(!running, "R4 request while disabled dropped", int'(running), 0);

        // R2 table walk, continuous software start
        for (int v = 0; v < NVEC; v++) begin
            int hi;
            int bad;
            arr_val  = 16'(TBL[v][0]);
            cmp_val  = 16'(TBL[v][1]);
            polarity = TBL[v][2][0];
            renable();
            pulse_cont();
            tick(2);
            hi  = 0;
            bad = 0;
            for (int i = 0; i <= TBL[v][0]; i++) begin
                if (count != 16'(i)) bad++;
                if (wave_out != polarity) hi++;
                tick(1);
            end
            chk(bad == 0 && count == 0, "R2 count sequence and wrap", bad, 0);
            chk(hi == TBL[v][3], "R2 active cycles per period", hi, TBL[v][3]);
        end
        polarity = 1'b0;

        // R3 software start latency
        arr_val = 16'd5;
        cmp_val = 16'd2;
        renable();
        pulse_cont();
        tick(1);
        chk(!running, "R3 not yet running", int'(running), 0);
        tick(1);
        chk(running && count == 0, "R3 running on third edge", int'(running), 1);

        // R7 continuous keeps running across overflow
        tick(8);
        chk(running && count == 2, "R7 continuous wraps and runs", int'(count), 2);

        // R12 single request during continuous: stop at next update
        renable();
        pulse_cont();
        tick(3);
        pulse_single();
        tick(4);
        chk(!running && count == 0, "R12 stops at update", int'(running), 0);
        tick(4);
        chk(!running, "R12 stays stopped", int'(running), 0);

        // R5 one-shot run length and R11 overflow flag
        clr_arr = 1'b1;
        tick(1);
        clr_arr = 1'b0;
        pulse_single();
        tick(2);
        tick(5);
        chk(running && count == 5 && !flag_arr, "R5 last count of one-shot",
            int'(count), 5);
        tick(1);
        chk(!running && count == 0, "R5 stopped after period", int'(running), 0);
        chk(flag_arr, "R11 overflow flag set", int'(flag_arr), 1);

        // R12 continuous request during one-shot keeps running
        arr_val = 16'd20;
        cmp_val = 16'd10;
        renable();
        pulse_single();
        tick(3);
        pulse_cont();
        tick(25);
        chk(running, "R12 continuous past limit", int'(running), 1);

        // R10 rising-edge start, latency; R11 trigger flag; R6 discard
        trig_sel = 2'b01;
        renable();
        pulse_single();
        clr_trig = 1'b1;
        tick(1);
        clr_trig = 1'b0;
        ext_trig = 1'b1;
        tick(2);
        chk(!running, "R10 no start before sync delay", int'(running), 0);
        tick(1);
        chk(running && count == 0, "R10 rising edge starts", int'(running), 1);
        chk(flag_trig, "R11 trigger flag on accepted start", int'(flag_trig), 1);
        clr_trig = 1'b1;
        tick(1);
        clr_trig = 1'b0;
        chk(!flag_trig, "R11 trigger flag cleared", int'(flag_trig), 0);
        ext_trig = 1'b0;
        tick(2);
        ext_trig = 1'b1;
        tick(4);
        chk(count == 7, "R6 retrigger discarded in one-shot", int'(count), 7);
        chk(!flag_trig, "R11 no flag for discarded trigger", int'(flag_trig), 0);
        wait_stop(40);
        chk(!running, "R5 one-shot stopped", int'(running), 0);
        ext_trig = 1'b0;
        tick(3);
        ext_trig = 1'b1;
        tick(3);
        chk(running && count == 0, "R5 new trigger restarts", int'(running), 1);

        // R10 edge kind selection: falling only
        trig_sel = 2'b10;
        renable();
        pulse_cont();
        ext_trig = 1'b0;
        tick(3);
        chk(running, "R10 falling edge starts", int'(running), 1);
        renable();
        pulse_cont();
        ext_trig = 1'b1;
        tick(5);
        chk(!running, "R10 rising ignored when falling selected", int'(running), 0);

        // R9 timeout with both edges
        trig_sel   = 2'b11;
        timeout_en = 1'b1;
        arr_val    = 16'd30;
        cmp_val    = 16'd20;
        renable();
        pulse_cont();
        clr_cmp = 1'b1;
        tick(1);
        clr_cmp = 1'b0;
        ext_trig = 1'b0;
        tick(3);
        chk(running && count == 0, "R10 both-edge start", int'(running), 1);
        clr_trig = 1'b1;
        tick(1);
        clr_trig = 1'b0;
        tick(4);
        ext_trig = 1'b1;
        tick(3);
        chk(count == 0 && running, "R9 retrigger resets count", int'(count), 0);
        chk(flag_trig, "R9 retrigger flag", int'(flag_trig), 1);
        tick(19);
        chk(!flag_cmp && count == 19, "R9 no timeout before threshold", int'(flag_cmp), 0);
        tick(3);
        chk(flag_cmp, "R9 timeout compare flag", int'(flag_cmp), 1);
        timeout_en = 1'b0;

        // R7 continuous ignores later triggers
        trig_sel = 2'b01;
        arr_val  = 16'd30;
        renable();
        pulse_cont();
        ext_trig = 1'b0;
        tick(2);
        ext_trig = 1'b1;
        tick(3);
        tick(5);
        ext_trig = 1'b0;
        tick(2);
        ext_trig = 1'b1;
        tick(3);
        chk(count == 10, "R7 trigger ignored in continuous", int'(count), 10);

        // R8 set-once: latched output, later start ignored
        trig_sel = 2'b00;
        set_once = 1'b1;
        arr_val  = 16'd5;
        cmp_val  = 16'd2;
        renable();
        pulse_single();
        tick(2);
        wait_stop(20);
        tick(1);
        chk(!running && wave_out == 1'b1, "R8 output stays active", int'(wave_out), 1);
        pulse_single();
        tick(4);
        chk(!running && count == 0, "R8 second start ignored", int'(running), 0);
        chk(wave_out == 1'b1, "R8 output still active", int'(wave_out), 1);
        set_once = 1'b0;

        // R11 set beats clear on the same edge
        arr_val = 16'd5;
        renable();
        pulse_cont();
        tick(2);
        clr_arr = 1'b1;
        tick(1);
        clr_arr = 1'b0;
        tick(4);
        chk(count == 5 && !flag_arr, "R11 flag clear before overflow", int'(flag_arr), 0);
        clr_arr = 1'b1;
        tick(1);
        clr_arr = 1'b0;
        chk(flag_arr, "R11 set wins over clear", int'(flag_arr), 1);

        // R14 preload: held until gated update event
        preload  = 1'b1;
        upd_gate = 1'b0;
        arr_val  = 16'd5;
        renable();
        pulse_cont();
        tick(2);
        tick(1);
        arr_val = 16'd9;
        tick(5);
        chk(count == 0, "R14 preload holds old limit", int'(count), 0);
        upd_gate = 1'b1;
        tick(6);
        tick(6);
        chk(count == 6, "R14 new limit after update", int'(count), 6);
        upd_gate = 1'b1;

        // R14 immediate update without preload
        preload = 1'b0;
        arr_val = 16'd5;
        renable();
        pulse_cont();
        tick(2);
        tick(1);
        arr_val = 16'd9;
        tick(5);
        chk(count == 6, "R14 immediate limit change", int'(count), 6);

        // R4 disable clears state
        enable = 1'b0;
        tick(1);
        chk(!running && count == 0, "R4 disable clears counter", int'(count), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule